// File: doc/BRIEF.md
# Serial Port Register Front-End

This block is the register face of a serial port controller, seen by a processor through a simple word-wide bus inside a 1 KB address window. It keeps a status word, a receive data word, a baud divisor, three control words and a guard/prescale word. Bit-level serialization happens elsewhere. On the receive side the block takes whole bytes from a valid/ready byte stream. On the transmit side it hands out whole bytes with a one-cycle valid strobe. The far side is taken to always be ready.

Three status flags are kept up to date: receive-data-present, transmit-empty and transmit-done. A single level interrupt is raised when a received byte is waiting and the receive interrupt enable is on. Software drains the byte by reading the data word. The status word has a two-way write rule. Small values load it directly. Large values act as an AND mask that can only clear bits. Transmit-empty survives every write.

Top module: `uart_csr_frontend`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0x0C0, the data word (0x04) and every control word read 0, and irq and tx_valid are low.
- R2: rx_ready is high exactly while status bit 5 (receive-data-present) is clear. A byte offered while it is set is not taken, and the data word keeps its value.
- R3: A byte handed over (rx_valid and rx_ready high at a clock edge) is stored only when control word one (offset 0x0C) has bit 13 (enable) and bit 2 (receive enable) both set. Otherwise it is dropped, and status, data and irq are unchanged.
- R4: A stored byte appears in the data word and sets status bit 5. If control word one bit 5 (receive interrupt enable) is set, irq goes high at the same edge.
- R5: A read of the data word returns its value zero-extended from the low 10 bits. The edge that ends the read clears status bit 5 and drives irq low.
- R6: A status write of 0x3FF or less loads the status word with the written value, with bit 7 forced to 1.
- R7: A status write above 0x3FF ANDs the status word with the low 10 bits of the written value. Bit 7 still reads 1 afterwards.
- R8: After any status write whose result has bit 5 clear, irq is low.
- R9: A data-word write below 0xF000 produces one tx_valid cycle carrying the low byte and sets status bit 6 (transmit done). A write of 0xF000 or more produces no strobe and leaves status unchanged.
- R10: A write to control word one stores the value. If the new bit 5 is set while status bit 5 is set, irq goes high.
- R11: The baud word (0x08), control words two (0x10) and three (0x14), and the guard word (0x18) store and read back any 32-bit value.
- R12: A read at any other offset returns 0. A write at any other offset changes no readable word and no output.
- R13: Status bit 7 (transmit empty) reads 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block can take a byte |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte to transmit |
| irq | output | 1 | Level interrupt |

## Verification
The receive path is offered bytes in three situations: with the port disabled, with only the global enable on, and with both enables on. It is also offered a byte while a byte is already waiting. This separates enable gating from flag gating. The interrupt is armed in two ways, before the byte arrives and by a control write afterwards, and it is cleared once by a data read and once by a status write. Status writes use values just under and just over the 0x3FF threshold, so the load rule and the mask rule can be told apart. Data writes on either side of 0xF000 show strobe suppression.

// File: rtl/uart_csr_pkg.sv
package uart_csr_pkg;
  // word slots inside the window, slot n sits at byte offset 4*n
  localparam int unsigned SLOT_SR     = 0;
  localparam int unsigned SLOT_DR     = 1;
  localparam int unsigned SLOT_BRR    = 2;
  localparam int unsigned SLOT_CR1    = 3;
  localparam int unsigned SLOT_CR2    = 4;
  localparam int unsigned SLOT_CR3    = 5;
  localparam int unsigned SLOT_GTPR   = 6;
  localparam int unsigned NUM_SLOTS   = 7;
  localparam int unsigned SLOT_STRIDE = 4;

  // status bit positions
  localparam int unsigned ST_TXE  = 7;
  localparam int unsigned ST_TC   = 6;
  localparam int unsigned ST_RXNE = 5;

  // control word one bit positions
  localparam int unsigned C1_EN    = 13;
  localparam int unsigned C1_RXIE  = 5;
  localparam int unsigned C1_RXEN  = 2;
endpackage

// File: rtl/uart_csr_decode.sv
module uart_csr_decode #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned SLOTS  = 7,
  parameter int unsigned STRIDE = 4
) (
  input  logic              bus_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [SLOTS-1:0]  hit
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign hit[g] = bus_sel && (bus_addr == ADDR_W'(g * STRIDE));
  end
endmodule

// File: rtl/uart_csr_word.sv
module uart_csr_word #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end
endmodule

// File: rtl/uart_csr_flags.sv
module uart_csr_flags
  import uart_csr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned SR_W    = 10,
  parameter logic [DATA_W-1:0] LOAD_LIMIT = 32'h0000_03FF,
  parameter logic [DATA_W-1:0] TX_CUTOFF  = 32'h0000_F000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_wr,
  input  logic              dr_wr,
  input  logic              dr_rd,
  input  logic              cr1_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cr1_q,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic [SR_W-1:0]   sr_q,
  output logic [CHAR_W-1:0] dr_q,
  output logic              irq,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data
);
  localparam logic [SR_W-1:0] SR_RESET = SR_W'((1 << ST_TXE) | (1 << ST_TC));

  // status write rule: small values load, large values mask; TXE always kept
  function automatic logic [SR_W-1:0] sr_after_write(input logic [SR_W-1:0] cur,
                                                     input logic [DATA_W-1:0] wd);
    logic [SR_W-1:0] r;
    if (wd <= LOAD_LIMIT) r = wd[SR_W-1:0];
    else                  r = cur & wd[SR_W-1:0];
    r[ST_TXE] = 1'b1;
    return r;
  endfunction

  function automatic logic tx_accepts(input logic [DATA_W-1:0] wd);
    return wd < TX_CUTOFF;
  endfunction

  logic            rx_take, dr_wr_ok, rx_open;
  logic [SR_W-1:0] sr_n;
  logic [CHAR_W-1:0] dr_n;
  logic            irq_n;

  assign rx_ready = !sr_q[ST_RXNE];
  assign rx_open  = cr1_q[C1_EN] && cr1_q[C1_RXEN];
  assign rx_take  = rx_valid && rx_ready && rx_open;
  assign dr_wr_ok = dr_wr && tx_accepts(wdata);

  always_comb begin
    sr_n  = sr_q;
    dr_n  = dr_q;
    irq_n = irq;
    if (sr_wr) begin
      sr_n = sr_after_write(sr_q, wdata);
      if (!sr_n[ST_RXNE]) irq_n = 1'b0;
    end
    if (dr_wr_ok) sr_n[ST_TC] = 1'b1;
    if (dr_rd) begin
      sr_n[ST_RXNE] = 1'b0;
      irq_n         = 1'b0;
    end
    if (cr1_wr && wdata[C1_RXIE] && sr_n[ST_RXNE]) irq_n = 1'b1;
    if (rx_take) begin
      dr_n          = rx_data;
      sr_n[ST_RXNE] = 1'b1;
      if (cr1_q[C1_RXIE]) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q     <= SR_RESET;
      dr_q     <= '0;
      irq      <= 1'b0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      sr_q     <= sr_n;
      dr_q     <= dr_n;
      irq      <= irq_n;
      tx_valid <= dr_wr_ok;
      if (dr_wr_ok) tx_data <= wdata[CHAR_W-1:0];
    end
  end

  // R2: a byte offered while one is waiting leaves the data word alone
  p_hold_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && sr_q[ST_RXNE]) |=> $stable(dr_q));
  // R3: a byte offered with the port closed changes nothing
  p_drop_when_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_open) |=> $stable(dr_q));
  // R4: a taken byte raises the data-present flag
  p_take_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_open) |=> sr_q[ST_RXNE]);
  // R5: a data read drains the flag and the interrupt
  p_read_drains_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_rd && !rx_take) |=> (!sr_q[ST_RXNE] && !irq));
  // R9: an accepted data write strobes the transmitter and sets transmit-done
  p_tx_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dr_wr_ok |=> (tx_valid && sr_q[ST_TC]));
  // R10: arming the enable with a byte waiting raises irq
  p_arm_raises_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cr1_wr && wdata[C1_RXIE] && sr_q[ST_RXNE]) |=> irq);
  // R13: transmit-empty never drops
  p_txe_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
    sr_q[ST_TXE]);
endmodule

// File: rtl/uart_csr_frontend.sv
module uart_csr_frontend
  import uart_csr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CHAR_W  = 8,
  parameter int unsigned SR_W    = 10,
  parameter int unsigned DRVIEW_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [CHAR_W-1:0] tx_data,
  output logic              irq
);
  logic [NUM_SLOTS-1:0] hit, wr_hit, rd_hit;
  logic [DATA_W-1:0]    slot_q [NUM_SLOTS];
  logic [SR_W-1:0]      sr_q;
  logic [CHAR_W-1:0]    dr_q;
  logic [DRVIEW_W-1:0]  dr_view;

  uart_csr_decode #(.ADDR_W(ADDR_W), .SLOTS(NUM_SLOTS), .STRIDE(SLOT_STRIDE)) u_decode (
    .bus_sel (bus_sel),
    .bus_addr(bus_addr),
    .hit     (hit)
  );

  assign wr_hit = bus_wr  ? hit : '0;
  assign rd_hit = !bus_wr ? hit : '0;

  // plain storage words; status and data live in the flag engine
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_store
    if (g == SLOT_SR || g == SLOT_DR) begin : g_none
      assign slot_q[g] = '0;
    end else begin : g_word
      uart_csr_word #(.W(DATA_W)) u_word (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (wr_hit[g]),
        .wdata(bus_wdata),
        .q    (slot_q[g])
      );
    end
  end

  uart_csr_flags #(.DATA_W(DATA_W), .CHAR_W(CHAR_W), .SR_W(SR_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .sr_wr   (wr_hit[SLOT_SR]),
    .dr_wr   (wr_hit[SLOT_DR]),
    .dr_rd   (rd_hit[SLOT_DR]),
    .cr1_wr  (wr_hit[SLOT_CR1]),
    .wdata   (bus_wdata),
    .cr1_q   (slot_q[SLOT_CR1]),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_ready(rx_ready),
    .sr_q    (sr_q),
    .dr_q    (dr_q),
    .irq     (irq),
    .tx_valid(tx_valid),
    .tx_data (tx_data)
  );

  assign dr_view = DRVIEW_W'(dr_q);

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < int'(NUM_SLOTS); i++) begin
      if (rd_hit[i]) begin
        if (i == int'(SLOT_SR))      bus_rdata = DATA_W'(sr_q);
        else if (i == int'(SLOT_DR)) bus_rdata = DATA_W'(dr_view);
        else                         bus_rdata = slot_q[i];
      end
    end
  end

  // R12: a read that hits no word returns zero
  p_unmapped_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && (hit == '0)) |-> (bus_rdata == '0));
  // R1: interrupt and strobe are low on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq && !tx_valid));
endmodule

// File: tb/test_uart_csr_frontend.sv
module test_uart_csr_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, tx_valid, irq;
  logic [7:0]  tx_data;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] tx_q [$];
  bit done = 0;

  always #4 clk = ~clk;

  uart_csr_frontend i_uart_csr_frontend (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // expected status: bit7 always, RXNE and TC tracked by the bench
  function automatic logic [31:0] sr_rule(logic [31:0] cur, logic [31:0] wd);
    logic [31:0] r;
    r = (wd > 32'h3FF) ? (cur & wd & 32'h3FF) : wd;
    return r | 32'h80;
  endfunction

  task automatic bus_write(logic [9:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    if (a == 10'h04 && d < 32'hF000) tx_q.push_back(d[7:0]);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic bus_read(string req, logic [9:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 check(req, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  // monitor: pops expected transmit bytes as strobes appear
  always @(negedge clk) begin
    if (rst_n && tx_valid) begin
      if (tx_q.size() == 0) begin
        compared++; mismatched++;
        $display("FAIL R9: unexpected strobe 0x%0h expected none", tx_data);
      end else begin
        check("R9 tx byte", {24'h0, tx_data}, {24'h0, tx_q.pop_front()});
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    logic [31:0] sr;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {31'h0, irq}, 0);
    check("R1 tx_valid", {31'h0, tx_valid}, 0);
    bus_read("R1 status", 10'h00, 32'h0C0);
    bus_read("R1 data", 10'h04, 0);
    bus_read("R1 baud", 10'h08, 0);
    bus_read("R1 ctl1", 10'h0C, 0);
    bus_read("R1 guard", 10'h18, 0);
    check("R2 ready idle", {31'h0, rx_ready}, 1);
    sr = 32'h0C0;

    // R3 port closed, then only global enable
    send_byte(8'h11);
    bus_read("R3 status closed", 10'h00, sr);
    bus_read("R3 data closed", 10'h04, 0);
    bus_write(10'h0C, 32'h2000);
    send_byte(8'h22);
    bus_read("R3 status half-open", 10'h00, sr);
    check("R3 irq", {31'h0, irq}, 0);

    // R4 open port, no interrupt enable
    bus_write(10'h0C, 32'h2004);
    send_byte(8'h5A);
    sr = sr | 32'h20;
    bus_read("R4 status after byte", 10'h00, sr);
    check("R2 ready with byte", {31'h0, rx_ready}, 0);
    check("R4 irq off", {31'h0, irq}, 0);
    send_byte(8'h99);
    bus_read("R5 data read", 10'h04, 32'h5A);
    sr = sr & ~32'h20;
    bus_read("R5 status after read", 10'h00, sr);
    check("R2 ready again", {31'h0, rx_ready}, 1);

    // R10 arming after the byte arrived
    send_byte(8'h33);
    check("R10 irq before arm", {31'h0, irq}, 0);
    bus_write(10'h0C, 32'h2024);
    check("R10 irq after arm", {31'h0, irq}, 1);
    bus_read("R10 ctl1 stored", 10'h0C, 32'h2024);
    bus_read("R5 data", 10'h04, 32'h33);
    check("R5 irq dropped", {31'h0, irq}, 0);

    // R4 armed beforehand, R8 cleared by status write
    send_byte(8'hA7);
    check("R4 irq on", {31'h0, irq}, 1);
    bus_write(10'h00, 32'h0);
    sr = sr_rule(sr, 0);
    check("R8 irq after status write", {31'h0, irq}, 0);
    bus_read("R8 status", 10'h00, sr);

    // R6 / R7 / R13 write rule
    bus_write(10'h00, 32'h3FF); sr = sr_rule(sr, 32'h3FF);
    bus_read("R6 load max", 10'h00, sr);
    bus_write(10'h00, 32'hFFFF_FFDF); sr = sr_rule(sr, 32'hFFFF_FFDF);
    bus_read("R7 mask", 10'h00, sr);
    bus_write(10'h00, 32'h0000_0400); sr = sr_rule(sr, 32'h400);
    bus_read("R13 txe kept by mask", 10'h00, sr);
    bus_write(10'h00, 32'h001); sr = sr_rule(sr, 32'h001);
    bus_read("R6 load small", 10'h00, sr);
    bus_write(10'h00, 32'h0); sr = sr_rule(sr, 0);

    // R9 transmit
    bus_write(10'h04, 32'h0000_1234); sr = sr | 32'h40;
    bus_read("R9 tc set", 10'h00, sr);
    bus_write(10'h00, 32'h0); sr = sr_rule(sr, 0);
    bus_write(10'h04, 32'h0000_F000);
    bus_read("R9 ignored write", 10'h00, sr);
    bus_write(10'h04, 32'h0000_EFFF); sr = sr | 32'h40;
    bus_read("R9 edge write", 10'h00, sr);

    // R11 plain storage
    bus_write(10'h08, 32'h1234_5678);
    bus_write(10'h10, 32'hA5A5_A5A5);
    bus_write(10'h14, 32'h0F0F_00FF);
    bus_write(10'h18, 32'hFFFF_FFFF);
    bus_read("R11 baud", 10'h08, 32'h1234_5678);
    bus_read("R11 ctl2", 10'h10, 32'hA5A5_A5A5);
    bus_read("R11 ctl3", 10'h14, 32'h0F0F_00FF);
    bus_read("R11 guard", 10'h18, 32'hFFFF_FFFF);

    // R12 unmapped
    bus_read("R12 read 0x1C", 10'h1C, 0);
    bus_read("R12 read 0x3FC", 10'h3FC, 0);
    bus_read("R12 read unaligned", 10'h09, 0);
    bus_write(10'h20, 32'hDEAD_BEEF);
    bus_write(10'h0A, 32'h0);
    bus_read("R12 baud kept", 10'h08, 32'h1234_5678);
    bus_read("R12 status kept", 10'h00, sr);
    check("R12 irq", {31'h0, irq}, 0);

    repeat (3) @(negedge clk);
    check("R9 queue drained", tx_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule